// File: doc/BRIEF.md
# Two-Stage Key-Protected Watchdog Timer

This block is a watchdog peripheral on a small register bus: an address, a write strobe, a read strobe, a write-data word and a read-data word. A prescaler divides the system clock into a count tick, fast or slow. Once the block is enabled, a first countdown stage runs from its own preload. When that stage runs out, the block can pulse an interrupt line and then starts a second countdown stage. If the second stage also runs out, the block sets a sticky timeout flag and can send out a reset request pulse of fixed length. After that the counters stay idle until the block is enabled again.

The two preload registers and the keep-alive register are guarded. Software must first write the two key words to the keep-alive address, 0x80 and then 0x86. This opens the gate for exactly one later bus write. A keep-alive write restarts the first stage. A lock bit, once set, holds the enable on until the block is reset. A plain timer mode makes the first stage repeat with an interrupt on each period, and never requests a reset. The live count of the running stage can be read at any time.

The bus has no handshake. A write takes effect on the clock edge at which the write strobe is sampled. Read data is combinational from the address while the read strobe is high, and zero otherwise.

Top module: `wdt2_watchdog`

## Requirements
- R1: After reset, every readable register returns 0, and both the interrupt line and the reset request are low.
- R2: Address map: 0 is the stage-one preload, 1 is the stage-two preload, 2 is the keep-alive/key register, 3 is control, 4 is configuration and 5 is the live count. A write to address 0 or 1 changes the preload only when it directly follows the key pair: the full word 0x80 and then the full word 0x86, both written to address 2. Otherwise the write is ignored.
- R3: The partial key is discarded by any write between the two key words, or by a second word other than 0x86. After that, a following write to a preload is ignored.
- R4: An open key is used up by the next bus write, whatever its address. A second protected write needs a new key.
- R5: With configuration bit 2 = 1, a tick occurs every 32 clocks. With a stage-one preload N≥1 (0 acts as 1), the interrupt pulse appears on the 1+32·N-th clock after the enabling control write (control bit 1 = enable, bit 2 = 0 for watchdog mode).
- R6: Configuration bits 1:0 equal to 3 suppress the interrupt. Any other value gives a one-clock interrupt pulse at the end of stage one. The second stage runs in either case.
- R7: With configuration bit 5 = 1, the end of stage two (preload M) raises the reset request on clock 1+32·(N+M) for exactly 8 clocks. It also sets the sticky flag, read as bit 9 at address 2. Afterwards the live count reads 0.
- R8: With configuration bit 5 = 0, the end of stage two sets the flag and gives no reset request.
- R9: A keyed write to address 2 with bit 8 set restarts stage one and its prescaler, and the interrupt follows 32·N clocks later. The same write without the key has no effect.
- R10: A keyed write to address 2 with bit 9 set clears the flag. An unkeyed write, or a keyed keep-alive alone, leaves the flag set.
- R11: Once control bit 0 (lock) is set together with the enable, neither the lock nor the enable can be cleared until reset. Control writes need no key.
- R12: With control bit 2 = 1 (timer mode), stage one reloads itself at every end, with an interrupt every 32·N clocks. No reset request is made and the flag stays clear.
- R13: Address 5 returns the live count of the running stage. It starts at the preload and falls by one on each tick.
- R14: With configuration bit 2 = 0, a tick occurs every 32768 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one write per sampled clock |
| bus_rd | input | 1 | Read strobe, qualifies read data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| irq_o | output | 1 | One-clock pulse at the end of stage one |
| rst_req_o | output | 1 | Reset request pulse at the end of stage two |

## Verification
Five stimulus rows combine different preload pairs, interrupt types and reset-enable settings, including a zero preload. These rows separate the stage-one timing from the stage-two timing, and separate interrupt suppression from reset suppression. Key sequences are tried with an intervening write, a wrong second word, a repeated protected write and a write with no key, so a gate that stays open or ignores ordering shows up. The timing of a keep-alive with and without the key, timer-mode repetition, the slow rate, a mid-count read of the live value and lock persistence across a disabling write then each expose one separate path.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PRE1 = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRE2 = 3'd1;
  localparam logic [ADDR_W-1:0] A_KICK = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd4;
  localparam logic [ADDR_W-1:0] A_LIVE = 3'd5;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  typedef enum logic [1:0] {K_SHUT, K_HALF, K_OPEN} key_st_e;
  typedef enum logic [2:0] {C_IDLE, C_STG1, C_STG2, C_PULSE, C_HALT} cd_st_e;
endpackage

// File: rtl/wdt2_keygate.sv
module wdt2_keygate
  import wdt2_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              open_o
);
  localparam logic [DW-1:0] K1 = DW'(KEY_FIRST);
  localparam logic [DW-1:0] K2 = DW'(KEY_SECOND);

  key_st_e st_q;
  logic    hit1, hit2;

  assign hit1 = (addr_i == A_KICK) && (wdata_i == K1);
  assign hit2 = (addr_i == A_KICK) && (wdata_i == K2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= K_SHUT;
    end else if (wr_i) begin
      case (st_q)
        K_SHUT:  if (hit1) st_q <= K_HALF;
        K_HALF:  st_q <= hit2 ? K_OPEN : K_SHUT;
        default: st_q <= K_SHUT;
      endcase
    end
  end

  assign open_o = (st_q == K_OPEN);

  // R4
  open_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && wr_i) |=> !open_o);

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(wr_i && hit2));
endmodule

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
  parameter int SLOW_LOG = 15,
  parameter int FAST_LOG = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  input  logic fast_i,
  output logic tick_o
);
  logic [SLOW_LOG-1:0] div_q;
  logic                fast_wrap, slow_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (!run_i || clear_i) div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end

  assign fast_wrap = &div_q[FAST_LOG-1:0];
  assign slow_wrap = &div_q;
  assign tick_o    = run_i && (fast_i ? fast_wrap : slow_wrap);

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdt2_countdown.sv
module wdt2_countdown
  import wdt2_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int RST_PULSE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             timer_mode_i,
  input  logic             irq_en_i,
  input  logic             rst_en_i,
  input  logic             reload_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] pre1_i,
  input  logic [CNT_W-1:0] pre2_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             restart_o,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             expire2_o
);
  localparam int PW = $clog2(RST_PULSE + 1);

  cd_st_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    pcnt_q;
  logic             en_prev_q, irq_q, rst_q;
  logic             start, kick, last, expire1;

  assign start     = enable_i && !en_prev_q;
  assign run_o     = (st_q == C_STG1) || (st_q == C_STG2);
  assign kick      = reload_i && run_o;
  assign last      = tick_i && (cnt_q <= CNT_W'(1));
  assign expire1   = enable_i && !start && !kick && (st_q == C_STG1) && last;
  assign expire2_o = enable_i && !start && !kick && (st_q == C_STG2) && last;
  assign restart_o = start || kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= C_IDLE;
      cnt_q     <= '0;
      pcnt_q    <= '0;
      en_prev_q <= 1'b0;
      irq_q     <= 1'b0;
      rst_q     <= 1'b0;
    end else begin
      en_prev_q <= enable_i;
      irq_q     <= expire1 && irq_en_i;
      if (!enable_i) begin
        st_q   <= C_IDLE;
        cnt_q  <= '0;
        pcnt_q <= '0;
        rst_q  <= 1'b0;
      end else if (start || kick) begin
        st_q  <= C_STG1;
        cnt_q <= pre1_i;
      end else begin
        case (st_q)
          C_STG1: if (tick_i) begin
            if (last) begin
              cnt_q <= timer_mode_i ? pre1_i : pre2_i;
              if (!timer_mode_i) st_q <= C_STG2;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          C_STG2: if (tick_i) begin
            if (last) begin
              cnt_q <= '0;
              if (rst_en_i) begin
                st_q   <= C_PULSE;
                rst_q  <= 1'b1;
                pcnt_q <= PW'(RST_PULSE - 1);
              end else begin
                st_q <= C_HALT;
              end
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          C_PULSE: begin
            if (pcnt_q == '0) begin
              st_q  <= C_HALT;
              rst_q <= 1'b0;
            end else begin
              pcnt_q <= pcnt_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign count_o   = cnt_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  // R9
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && enable_i) |=> (count_o == $past(pre1_i)));

  // R7
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (count_o == '0));
endmodule

// File: rtl/wdt2_watchdog.sv
module wdt2_watchdog
  import wdt2_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 20,
  parameter int SLOW_LOG  = 15,
  parameter int FAST_LOG  = 5,
  parameter int RST_PULSE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int B_LOCK  = 0;
  localparam int B_EN    = 1;
  localparam int B_MODE  = 2;
  localparam int B_RATE  = 2;
  localparam int B_RSTEN = 5;
  localparam int B_KICK  = 8;
  localparam int B_FLAG  = 9;

  logic [CNT_W-1:0]  pre1_q, pre2_q, live;
  logic              lock_q, en_q, mode_q, fast_q, rsten_q, flag_q;
  logic [1:0]        irqt_q;
  logic              key_open, keyed_wr, kick_wr;
  logic              run, restart, tick, expire2;
  logic [DATA_W-1:0] rd_mux;

  wdt2_keygate #(.DW(DATA_W)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .open_o(key_open)
  );

  assign keyed_wr = bus_wr && key_open;
  assign kick_wr  = keyed_wr && (bus_addr == A_KICK) && bus_wdata[B_KICK];

  wdt2_prescaler #(.SLOW_LOG(SLOW_LOG), .FAST_LOG(FAST_LOG)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(run), .clear_i(restart),
    .fast_i(fast_q), .tick_o(tick)
  );

  wdt2_countdown #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable_i(en_q), .timer_mode_i(mode_q),
    .irq_en_i(irqt_q != 2'b11), .rst_en_i(rsten_q), .reload_i(kick_wr),
    .tick_i(tick), .pre1_i(pre1_q), .pre2_i(pre2_q), .count_o(live),
    .run_o(run), .restart_o(restart), .irq_o(irq_o),
    .rst_req_o(rst_req_o), .expire2_o(expire2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre1_q  <= '0;
      pre2_q  <= '0;
      lock_q  <= 1'b0;
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      fast_q  <= 1'b0;
      rsten_q <= 1'b0;
      irqt_q  <= 2'b00;
      flag_q  <= 1'b0;
    end else begin
      if (keyed_wr && bus_addr == A_PRE1) pre1_q <= bus_wdata[CNT_W-1:0];
      if (keyed_wr && bus_addr == A_PRE2) pre2_q <= bus_wdata[CNT_W-1:0];
      if (bus_wr && bus_addr == A_CTRL) begin
        lock_q <= lock_q | bus_wdata[B_LOCK];
        en_q   <= bus_wdata[B_EN] | (lock_q & en_q);
        mode_q <= bus_wdata[B_MODE];
      end
      if (bus_wr && bus_addr == A_CFG) begin
        irqt_q  <= bus_wdata[1:0];
        fast_q  <= bus_wdata[B_RATE];
        rsten_q <= bus_wdata[B_RSTEN];
      end
      if (expire2) flag_q <= 1'b1;
      else if (keyed_wr && bus_addr == A_KICK && bus_wdata[B_FLAG]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_PRE1: rd_mux = DATA_W'(pre1_q);
      A_PRE2: rd_mux = DATA_W'(pre2_q);
      A_KICK: rd_mux[B_FLAG] = flag_q;
      A_CTRL: begin
        rd_mux[B_LOCK] = lock_q;
        rd_mux[B_EN]   = en_q;
        rd_mux[B_MODE] = mode_q;
      end
      A_CFG: begin
        rd_mux[1:0]     = irqt_q;
        rd_mux[B_RATE]  = fast_q;
        rd_mux[B_RSTEN] = rsten_q;
      end
      A_LIVE: rd_mux = DATA_W'(live);
      default: ;
    endcase
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && en_q) |=> (lock_q && en_q));

  // R7
  flag_with_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> flag_q);
endmodule

// File: tb/sim_wdt2_watchdog.sv
`timescale 1ns/1ps
module sim_wdt2_watchdog;
  localparam int DW = 32;
  localparam int RP = 8;

  typedef struct packed {
    int n; int m; int irqt; int rsten; int exp_irq; int exp_rst;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1, 1, 0, 1, 1 + 32*1, 1 + 32*2},
    '{3, 2, 1, 1, 1 + 32*3, 1 + 32*5},
    '{2, 4, 3, 1, -1,       1 + 32*6},
    '{4, 1, 2, 0, 1 + 32*4, -1},
    '{0, 0, 0, 1, 1 + 32*1, 1 + 32*2}
  };

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  wire  [DW-1:0] bus_rdata;
  wire           irq_o, rst_req_o;

  int  cyc = 0, n_chk = 0, n_bad = 0, wr_cyc = 0;
  int  first_irq, irq_hits, first_rst, rst_len;
  bit  done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt2_watchdog #(.DATA_W(DW), .CNT_W(20), .SLOW_LOG(15), .FAST_LOG(5),
                  .RST_PULSE(RP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(int a, int d);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = DW'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    wr_cyc = cyc;
  endtask

  task automatic keyed_write(int a, int d);
    bus_write(2, 'h80);
    bus_write(2, 'h86);
    bus_write(a, d);
  endtask

  task automatic read_now(int a, output int v);
    bus_addr = 3'(a); bus_rd = 1'b1;
    #1 v = int'(bus_rdata);
    bus_rd = 1'b0;
  endtask

  task automatic bus_read(int a, output int v);
    @(negedge clk);
    read_now(a, v);
  endtask

  task automatic observe(int n);
    first_irq = -1; irq_hits = 0; first_rst = -1; rst_len = 0;
    repeat (n) begin
      @(negedge clk);
      if (irq_o) begin irq_hits++; if (first_irq < 0) first_irq = cyc; end
      if (rst_req_o) begin rst_len++; if (first_rst < 0) first_rst = cyc; end
    end
  endtask

  task automatic arm(int n, int m, int irqt, int rsten, int fast, int mode);
    bus_write(3, 0);
    keyed_write(2, 'h200);
    bus_write(4, (rsten << 5) | (fast << 2) | irqt);
    keyed_write(0, n);
    keyed_write(1, m);
    bus_write(3, 2 | (mode << 2));
  endtask

  function automatic int rel(int at, int base);
    return (at < 0) ? -1 : at - base;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      bus_read(a, v);
      chk("R1 register after reset", v, 0);
    end
    chk("R1 irq after reset", int'(irq_o), 0);
    chk("R1 reset request after reset", int'(rst_req_o), 0);

    // R2 no key ignored, key accepted
    bus_write(0, 'h55); bus_read(0, v); chk("R2 unkeyed preload", v, 0);
    keyed_write(0, 'h55); bus_read(0, v); chk("R2 keyed preload", v, 'h55);

    // R4 one access per key
    bus_write(0, 'h66); bus_read(0, v); chk("R4 second write after key", v, 'h55);
    bus_write(2, 'h80); bus_write(2, 'h86); bus_write(4, 0); bus_write(1, 'h66);
    bus_read(1, v); chk("R4 key used by other address", v, 0);

    // R3 broken key sequences
    bus_write(2, 'h80); bus_write(4, 0); bus_write(2, 'h86); bus_write(0, 'h77);
    bus_read(0, v); chk("R3 intervening write", v, 'h55);
    bus_write(2, 'h80); bus_write(2, 'h81); bus_write(2, 'h86); bus_write(0, 'h77);
    bus_read(0, v); chk("R3 wrong second word", v, 'h55);

    // R5 R6 R7 R8 vector table
    foreach (VECS[i]) begin
      int nn, mm;
      nn = (VECS[i].n < 1) ? 1 : VECS[i].n;
      mm = (VECS[i].m < 1) ? 1 : VECS[i].m;
      arm(VECS[i].n, VECS[i].m, VECS[i].irqt, VECS[i].rsten, 1, 0);
      e = wr_cyc;
      observe(32 * (nn + mm) + RP + 40);
      chk("R5 R6 interrupt clock", rel(first_irq, e), VECS[i].exp_irq);
      chk("R7 R8 reset request clock", rel(first_rst, e), VECS[i].exp_rst);
      chk("R7 reset pulse length", rst_len, VECS[i].rsten ? RP : 0);
      bus_read(2, v); chk("R7 R8 flag set", (v >> 9) & 1, 1);
      bus_read(5, v); chk("R7 count idle after expiry", v, 0);
    end

    // R10 flag clearing rules
    bus_write(2, 'h200); bus_read(2, v); chk("R10 unkeyed clear", (v >> 9) & 1, 1);
    keyed_write(2, 'h100); bus_read(2, v); chk("R10 keep-alive keeps flag", (v >> 9) & 1, 1);
    keyed_write(2, 'h200); bus_read(2, v); chk("R10 keyed clear", (v >> 9) & 1, 0);

    // R9 keep-alive
    arm(3, 5, 0, 0, 1, 0);
    e = wr_cyc;
    repeat (40) @(negedge clk);
    bus_write(2, 'h100);
    observe(100);
    chk("R9 unkeyed keep-alive ignored", rel(first_irq, e), 97);
    keyed_write(2, 'h100);
    e = wr_cyc;
    observe(120);
    chk("R9 keyed keep-alive restarts", rel(first_irq, e), 96);

    // R13 live count
    arm(5, 5, 3, 0, 1, 0);
    e = wr_cyc;
    while (cyc < e + 70) @(negedge clk);
    read_now(5, v);
    chk("R13 live count after two ticks", v, 3);

    // R12 timer mode
    arm(2, 1, 0, 1, 1, 1);
    e = wr_cyc;
    observe(250);
    chk("R12 first timer interrupt", rel(first_irq, e), 65);
    chk("R12 interrupt count", irq_hits, 3);
    chk("R12 no reset request", rst_len, 0);
    bus_read(2, v); chk("R12 flag clear", (v >> 9) & 1, 0);

    // R14 slow rate
    arm(1, 1, 0, 0, 0, 0);
    e = wr_cyc;
    observe(32800);
    chk("R14 slow tick interrupt", rel(first_irq, e), 32769);

    // R11 lock
    arm(200, 200, 3, 0, 1, 0);
    bus_write(3, 3);
    bus_write(3, 0);
    bus_read(3, v); chk("R11 disable refused", v, 3);
    bus_write(3, 2);
    bus_read(3, v); chk("R11 lock persists", v, 3);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    bus_read(3, v); chk("R11 R1 lock cleared by reset", v, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule